// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block runs the power-up bring-up of a group of DDR SDRAM ranks once a start pulse arrives. It walks a fixed list of commands (a no-operation, precharges, an extended mode write that enables the DLL, a mode write that resets the DLL, eight auto-refresh cycles, a second mode write and a final switch to normal operation), spacing them with waits measured in ticks of an external microsecond strobe.

Every command except the final switch is offered, one rank at a time, to each rank that holds memory. The rank set is described by a table of cumulative end addresses in 32 MB units: a rank is visited only when its end lies above the last visited end, and it is addressed at that previous end. For mode writes the mode word is folded onto host address lines so that the memory sees it on its address pins. Each offer is held until the command port acknowledges it. When the whole list has run, a completion flag rises and stays up until the next start.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, `cmd_valid` and `init_done` are 0 and `cmd_code` is 0.
- R2: Command codes are NOP=1, precharge-all=2, mode write=3, extended mode write=4, auto-refresh=6, normal=7 (self-refresh=0). The issued order is 1, 2, 4, 3, 2, eight times 6, 3; normal (7) is then shown on `cmd_code` but never strobed.
- R3: Rank k's end is bits [8k+7:8k] of `rank_end`. Walking k=0..3 with a running end starting at 0, a rank is addressed only if its end is greater than the running end; its base is the running end shifted left by 25, and the running end then takes its value. Non-mode commands carry the bare base address.
- R4: For mode and extended mode writes, address bit 13 carries mode bit 11, address bits 12:3 carry mode bits 9:0, and address bits 2:0 and 24:14 are 0.
- R5: The extended mode write uses `ext_mode_word`; the first mode write uses `mode_word` with bit 8 (DLL reset) forced to 1, the second with bit 8 forced to 0.
- R6: A unit is 200 `us_tick` pulses. At least 2 units pass between start and the NOP; at least 3 units follow the NOP, each precharge, the extended mode write, each auto-refresh and the normal switch; mode writes have no following wait.
- R7: An offered command keeps `cmd_valid`, `cmd_code` and `cmd_addr` steady until `ack` is seen; the next rank or step is taken only after it.
- R8: `init_done` rises only after the wait that follows the normal switch, stays high until the next start, and drops in the cycle after a start is taken.
- R9: A start pulse while the sequence is running has no effect.
- R10: With no populated rank, no command is strobed and the sequence still completes with `init_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| us_tick | input | 1 | One-cycle microsecond strobe |
| rank_end | input | 32 | Four cumulative rank end values, 32 MB units |
| mode_word | input | 12 | Mode register contents |
| ext_mode_word | input | 12 | Extended mode register contents |
| ack | input | 1 | Command port accepted the offered command |
| cmd_code | output | 3 | Current command code |
| cmd_valid | output | 1 | A command is offered to a rank |
| cmd_addr | output | 33 | Rank base address plus mode bits |
| init_done | output | 1 | Initialization complete |

## Verification
Rank tables are chosen to separate the boundary rules: one rank only, all four in order, equal neighbouring ends that must be skipped, an empty first slot, a smaller later end, and an all-empty table. Mode words with bits 8, 10 and 11 set or clear tell the address fold and the DLL-reset forcing apart from a plain copy. A run with slow ticks and delayed acknowledges shows that waits are counted in ticks rather than cycles and that offers hold, and a stray start in mid-run shows it is ignored.

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
module ddr_init_seq #(
  parameter int RANKS       = 4,
  parameter int BND_W       = 8,
  parameter int UNIT_SHIFT  = 25,
  parameter int UNIT_TICKS  = 200,
  parameter int CBR_REPS    = 8,
  parameter int DLL_RST_BIT = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        us_tick,
  input  logic [RANKS*BND_W-1:0]      rank_end,
  input  logic [11:0]                 mode_word,
  input  logic [11:0]                 ext_mode_word,
  input  logic                        ack,
  output logic [2:0]                  cmd_code,
  output logic                        cmd_valid,
  output logic [BND_W+UNIT_SHIFT-1:0] cmd_addr,
  output logic                        init_done
);
  localparam int ADDR_W = BND_W + UNIT_SHIFT;
  localparam int LAST   = 6 + CBR_REPS;
  localparam int STEP_W = $clog2(LAST + 1);
  localparam int RIDX_W = (RANKS > 1) ? $clog2(RANKS) : 1;
  localparam int WAIT_W = $clog2(3 * UNIT_TICKS + 1);

  localparam logic [2:0] C_SELF = 3'd0, C_NOP = 3'd1, C_PRE = 3'd2, C_MRS = 3'd3,
                         C_EMRS = 3'd4, C_CBR = 3'd6, C_NORM = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_ISSUE, S_WAIT} st_t;

  function automatic logic [2:0] code_of(input int s);
    if (s == 0) return C_NOP;
    if (s == 1 || s == 4) return C_PRE;
    if (s == 2) return C_EMRS;
    if (s == 3 || s == 5 + CBR_REPS) return C_MRS;
    if (s < 5 + CBR_REPS) return C_CBR;
    return C_NORM;
  endfunction

  st_t               state;
  logic [STEP_W-1:0] step;
  logic [RIDX_W-1:0] ridx;
  logic [BND_W-1:0]  prev_end;
  logic [WAIT_W-1:0] wcnt;
  logic              done_q;

  logic [2:0]        code;
  logic [BND_W-1:0]  cur_end;
  logic              live;
  logic [11:0]       mw;
  logic [WAIT_W-1:0] wait_len;
  logic [ADDR_W-1:0] mofs;

  assign code     = code_of(int'(step));
  assign cur_end  = rank_end[int'(ridx)*BND_W +: BND_W];
  assign live     = (state == S_ISSUE) && (code != C_NORM) && (cur_end > prev_end);
  assign wait_len = (code == C_MRS) ? '0 : WAIT_W'(3 * UNIT_TICKS);

  always_comb begin
    mw = '0;
    if (code == C_EMRS) mw = ext_mode_word;
    else if (code == C_MRS && int'(step) == 3) mw = mode_word | (12'd1 << DLL_RST_BIT);
    else if (code == C_MRS) mw = mode_word & ~(12'd1 << DLL_RST_BIT);
  end

  assign mofs      = (code == C_MRS || code == C_EMRS) ? ADDR_W'({mw[11], mw[9:0], 3'b000}) : '0;
  assign cmd_addr  = {prev_end, {UNIT_SHIFT{1'b0}}} | mofs;
  assign cmd_valid = live;
  assign cmd_code  = (state == S_IDLE && !done_q) ? C_SELF : code;
  assign init_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step     <= '0;
      ridx     <= '0;
      prev_end <= '0;
      wcnt     <= '0;
      done_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_LEAD;
          step   <= '0;
          wcnt   <= '0;
          done_q <= 1'b0;
        end
        S_LEAD: begin
          if (wcnt == WAIT_W'(2 * UNIT_TICKS)) begin
            state    <= S_ISSUE;
            ridx     <= '0;
            prev_end <= '0;
          end else if (us_tick) wcnt <= wcnt + 1'b1;
        end
        S_ISSUE: begin
          if (code == C_NORM) begin
            state <= S_WAIT;
            wcnt  <= '0;
          end else if (!live || ack) begin
            if (live) prev_end <= cur_end;
            if (ridx == RIDX_W'(RANKS - 1)) begin
              state <= S_WAIT;
              wcnt  <= '0;
            end else ridx <= ridx + 1'b1;
          end
        end
        default: begin
          if (wcnt == wait_len) begin
            if (int'(step) == LAST) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              step     <= step + 1'b1;
              state    <= S_ISSUE;
              ridx     <= '0;
              prev_end <= '0;
            end
          end else if (us_tick) wcnt <= wcnt + 1'b1;
        end
      endcase
    end
  end

  // R7
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !ack |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_code));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done && !start |=> init_done);

  // R8
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !init_done);

  // R2
  normal_not_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_code != C_NORM && cmd_code != C_SELF);

  // R4
  plain_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code != C_MRS && cmd_code != C_EMRS |-> cmd_addr[UNIT_SHIFT-1:0] == '0);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && start && !ack |=> cmd_valid && $stable(cmd_code));
endmodule

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;
  localparam int RANKS = 4;
  localparam int UNIT  = 200;
  localparam int CBR   = 8;
  localparam int SLACK = 2 * RANKS + 8;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, us_tick = 1'b0, ack = 1'b0;
  logic [31:0] rank_end = '0;
  logic [11:0] mode_word = '0, ext_mode_word = '0;
  logic [2:0]  cmd_code;
  logic        cmd_valid, init_done;
  logic [32:0] cmd_addr;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ddr_init_seq u_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
    .rank_end(rank_end), .mode_word(mode_word), .ext_mode_word(ext_mode_word),
    .ack(ack), .cmd_code(cmd_code), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .init_done(init_done));

  // {ranks expected, rank_end, mode_word, ext_mode_word}
  localparam logic [58:0] VEC [6] = '{
    {3'd1, 32'h0000_0004, 12'h06A, 12'h000},
    {3'd3, 32'h1008_0804, 12'h06A, 12'h000},
    {3'd4, 32'h4030_2010, 12'hFFF, 12'h802},
    {3'd0, 32'h0000_0000, 12'h06A, 12'h000},
    {3'd1, 32'h0000_0800, 12'hB55, 12'h401},
    {3'd1, 32'h0810_0000, 12'h06A, 12'h000}
  };

  logic [2:0]  e_code [64];
  logic [32:0] e_addr [64];
  int          e_step [64];
  logic [2:0]  l_code [64];
  logic [32:0] l_addr [64];
  int          l_tick [64];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [32:0] fold(input logic [11:0] m);
    return {19'b0, m[11], m[9:0], 3'b000};
  endfunction

  function automatic logic [2:0] step_code(input int s);
    if (s == 0) return 3'd1;
    if (s == 1 || s == 4) return 3'd2;
    if (s == 2) return 3'd4;
    if (s == 3 || s == 5 + CBR) return 3'd3;
    return 3'd6;
  endfunction

  function automatic int gap_after(input int s);
    return (s == 3 || s == 5 + CBR) ? 0 : 3 * UNIT;
  endfunction

  task automatic run_seq(input logic [31:0] cfg, input logic [11:0] mw, input logic [11:0] ew,
                         input int nr_exp, input int tper, input int ack_dly, input bit poke);
    logic [32:0] bases [4];
    logic [7:0]  prev;
    logic [2:0]  h_code;
    logic [32:0] h_addr;
    int nb, nexp, nlog, tcount, phase, cyc, hold_n;
    bit poked, done_seen;
    nb = 0; prev = '0;
    for (int r = 0; r < RANKS; r++) begin
      if (cfg[r*8 +: 8] > prev) begin
        bases[nb] = {prev, 25'b0};
        nb++;
        prev = cfg[r*8 +: 8];
      end
    end
    check(nb == nr_exp, "R3", "populated ranks in table", 64'(nb), 64'(nr_exp));
    nexp = 0;
    for (int s = 0; s <= 5 + CBR; s++) begin
      logic [2:0]  c;
      logic [11:0] w;
      c = step_code(s);
      w = (s == 2) ? ew : (s == 3) ? (mw | 12'h100) : (s == 5 + CBR) ? (mw & ~12'h100) : 12'h000;
      for (int b = 0; b < nb; b++) begin
        e_code[nexp] = c;
        e_addr[nexp] = bases[b] | ((c == 3'd3 || c == 3'd4) ? fold(w) : 33'd0);
        e_step[nexp] = s;
        nexp++;
      end
    end

    rank_end = cfg; mode_word = mw; ext_mode_word = ew;
    @(negedge clk);
    start = 1'b1; us_tick = 1'b0; ack = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R8: a taken start clears the flag
    check(init_done == 1'b0, "R8", "done cleared by start", 64'(init_done), 64'd0);
    nlog = 0; tcount = 0; phase = 0; cyc = 0; hold_n = 0; poked = 0; done_seen = 0;
    h_code = '0; h_addr = '0;
    while (cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (init_done) begin
        done_seen = 1;
        break;
      end
      start = 1'b0;
      if (cmd_valid && !ack) begin
        if (hold_n == 0) begin
          h_code = cmd_code; h_addr = cmd_addr;
        end else begin
          // R7
          check(cmd_code == h_code && cmd_addr == h_addr, "R7", "offer held",
                64'(cmd_addr), 64'(h_addr));
        end
        if (hold_n < ack_dly) hold_n++;
        else begin
          if (nlog < 64) begin
            l_code[nlog] = cmd_code; l_addr[nlog] = cmd_addr; l_tick[nlog] = tcount;
          end
          nlog++;
          ack = 1'b1;
          hold_n = 0;
        end
      end else ack = 1'b0;
      if (poke && !poked && nlog == 5) begin
        start = 1'b1;
        poked = 1;
      end
      phase++;
      if (phase == tper) begin
        phase = 0; us_tick = 1'b1; tcount++;
      end else us_tick = 1'b0;
    end
    us_tick = 1'b0; ack = 1'b0; start = 1'b0;

    check(done_seen, "R8", "sequence reached done", 64'(done_seen), 64'd1);
    if (poke) check(poked && nlog == nexp, "R9", "stray start ignored", 64'(nlog), 64'(nexp));
    if (nr_exp == 0) check(nlog == 0, "R10", "no strobes when empty", 64'(nlog), 64'd0);
    else check(nlog == nexp, "R3", "number of issued commands", 64'(nlog), 64'(nexp));
    for (int i = 0; i < nexp && i < nlog; i++) begin
      check(l_code[i] == e_code[i], "R2", "command order", 64'(l_code[i]), 64'(e_code[i]));
      if (e_code[i] == 3'd3 || e_code[i] == 3'd4) begin
        check(l_addr[i] == e_addr[i], "R5", "mode word address", 64'(l_addr[i]), 64'(e_addr[i]));
        check(l_addr[i][2:0] == 3'b0 && l_addr[i][24:14] == '0, "R4", "fold leaves bits clear",
              64'(l_addr[i]), 64'(e_addr[i]));
      end else
        check(l_addr[i] == e_addr[i], "R3", "rank base address", 64'(l_addr[i]), 64'(e_addr[i]));
      if (i == 0)
        check(l_tick[0] >= 2 * UNIT && l_tick[0] <= 2 * UNIT + SLACK, "R6", "lead wait",
              64'(l_tick[0]), 64'(2 * UNIT));
      else if (e_step[i] != e_step[i-1])
        check(l_tick[i] - l_tick[i-1] >= gap_after(e_step[i-1]) &&
              l_tick[i] - l_tick[i-1] <= gap_after(e_step[i-1]) + SLACK, "R6", "step gap",
              64'(l_tick[i] - l_tick[i-1]), 64'(gap_after(e_step[i-1])));
    end
    check(tcount >= 41 * UNIT, "R6", "total ticks to done", 64'(tcount), 64'(41 * UNIT));
    if (nlog > 0)
      check(tcount - l_tick[nlog-1] >= 3 * UNIT, "R8", "wait after normal switch",
            64'(tcount - l_tick[nlog-1]), 64'(3 * UNIT));
    check(cmd_code == 3'd7 && cmd_valid == 1'b0, "R2", "normal shown, not strobed",
          64'(cmd_code), 64'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(cmd_valid == 1'b0, "R1", "valid in reset", 64'(cmd_valid), 64'd0);
    check(init_done == 1'b0, "R1", "done in reset", 64'(init_done), 64'd0);
    check(cmd_code == 3'd0, "R1", "code in reset", 64'(cmd_code), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (VEC[v])
      run_seq(VEC[v][55:24], VEC[v][23:12], VEC[v][11:0], int'(VEC[v][58:56]), 1, 0, 1'b0);
    repeat (20) @(negedge clk);
    // R8: flag holds with no start
    check(init_done == 1'b1 && cmd_valid == 1'b0, "R8", "done holds", 64'(init_done), 64'd1);
    // R7 and R6: slow ticks, late acknowledges
    run_seq(32'h2020_1008, 12'h5A5, 12'h001, 3, 3, 3, 1'b0);
    // R9: start pulse during the run
    run_seq(32'h4030_2010, 12'h06A, 12'h000, 4, 1, 0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule